// File: doc/BRIEF.md
# Single-Bank Precharge and Activate Timing Guard

This block follows one DRAM bank through its open, read and close commands and tells a memory controller, on every cycle, whether a precharge or an activate to that bank is legal right now. It enforces the minimum row-open time before any close. It enforces the row-precharge recovery time before the next open. It also models the internal precharge that a read with auto-close schedules on its own. Both analog delays are supplied in picoseconds together with the clock period, and they are rounded up to whole clock counts when the block is built.

The controller drives at most one command strobe per cycle. A strobe presented while its permission is low, or alongside a second strobe, is not acted on. It produces a violation pulse in the following cycle and leaves the tracked bank state untouched. A read with auto-close sets its internal close point at the earliest edge that does not cut the burst short, which is half the burst length in clocks after the read. If the minimum row-open time has not run out by then, the internal close waits until it has. Recovery time counts from the edge where the internal close actually happens.

Top module: `bank_pre_guard`

## Requirements
- R1: After reset, `act_ok` is 1, `pre_ok` is 0 and `viol` is 0.
- R2: After an accepted activate on cycle t, `pre_ok` stays 0 until cycle t + ceil(TRAS_PS / CLK_PS). It is 1 from that cycle onward while the bank is open and no auto-close is pending.
- R3: After a precharge starts on cycle t, whether external or internal, `act_ok` is 0 until cycle t + ceil(TRP_PS / CLK_PS), and 1 from then on.
- R4: An activate is accepted only while `act_ok` is 1. An activate with `act_ok` at 0 raises `viol` and changes no state.
- R5: A precharge with `pre_ok` at 0 raises `viol` and changes no state. This includes a precharge to a bank that is already closed.
- R6: A read or read-with-auto-close raises `viol` and is ignored when the bank is not open or when an auto-close is already pending.
- R7: An auto-close read accepted on cycle t starts the internal precharge on cycle t + BURST_LEN/2, provided the row-open time is met by then.
- R8: If the row-open time is not yet met on cycle t + BURST_LEN/2, the internal precharge starts on the first cycle where `pre_ok` would otherwise rise.
- R9: While an auto-close is pending, `pre_ok` is 0 and `act_ok` is 0.
- R10: Two or more command strobes in the same cycle raise `viol`, and none of them is acted on.
- R11: `viol` is 1 for exactly the one cycle after an illegal command and is 0 after any cycle with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_act | input | 1 | Activate (open a row) strobe |
| cmd_rd | input | 1 | Read strobe |
| cmd_rda | input | 1 | Read with auto-close strobe |
| cmd_pre | input | 1 | Precharge (close row) strobe |
| act_ok | output | 1 | An activate on this cycle is legal |
| pre_ok | output | 1 | An external precharge on this cycle is legal |
| viol | output | 1 | One-cycle flag for an illegal command in the previous cycle |

## Verification
The bench builds the guard with a 4000 ps period, 42000 ps row-open time and 15000 ps recovery time. These give 11 and 4 clocks, and both round up from a non-integer quotient, so an off-by-one in the ceiling shows up directly. A burst of 8 puts the ideal auto-close point 4 clocks after the read. That is well inside the 11-clock row-open window, so an auto-close read issued right after an activate exercises the postponed case. One issued late in the window exercises the on-time case. Random command streams then cross all of these windows against a timestamp model kept in the bench.

// File: rtl/bpg_pkg.sv
`timescale 1ns/1ps
package bpg_pkg;

   typedef enum logic [1:0] {
      BK_IDLE    = 2'd0,
      BK_OPEN    = 2'd1,
      BK_CLOSING = 2'd2
   } bank_st_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/bpg_down_cnt.sv
`timescale 1ns/1ps
module bpg_down_cnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic [CW-1:0] cnt,
   output logic          zero
);

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/bpg_bank_fsm.sv
`timescale 1ns/1ps
module bpg_bank_fsm
   import bpg_pkg::*;
#(
   parameter bit TRP_SINGLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_act,
   input  logic cmd_rd,
   input  logic cmd_rda,
   input  logic cmd_pre,
   input  logic ras_zero,
   input  logic ap_zero,
   input  logic rp_last,
   output logic act_ok,
   output logic pre_ok,
   output logic viol,
   output logic ld_ras,
   output logic ld_ap,
   output logic ld_rp
);

   bank_st_e st_q;
   bank_st_e close_st;
   logic     ap_pend_q;
   logic     one_cmd, any_cmd, is_open, rd_ok, fire;
   logic     leg_act, leg_pre, leg_rd, leg_rda, start_pre, bad;

   generate
      if (TRP_SINGLE) begin : g_rp_short
         assign close_st = BK_IDLE;
      end else begin : g_rp_long
         assign close_st = BK_CLOSING;
      end
   endgenerate

   always_comb begin
      one_cmd   = $onehot({cmd_act, cmd_rd, cmd_rda, cmd_pre});
      any_cmd   = cmd_act | cmd_rd | cmd_rda | cmd_pre;
      is_open   = (st_q == BK_OPEN);
      rd_ok     = is_open && !ap_pend_q;
      act_ok    = (st_q == BK_IDLE);
      pre_ok    = is_open && !ap_pend_q && ras_zero;
      fire      = is_open && ap_pend_q && ap_zero && ras_zero;
      leg_act   = cmd_act && one_cmd && act_ok;
      leg_pre   = cmd_pre && one_cmd && pre_ok;
      leg_rd    = cmd_rd  && one_cmd && rd_ok;
      leg_rda   = cmd_rda && one_cmd && rd_ok;
      start_pre = leg_pre || fire;
      bad       = any_cmd && !(leg_act || leg_pre || leg_rd || leg_rda);
      ld_ras    = leg_act;
      ld_ap     = leg_rda;
      ld_rp     = start_pre;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= BK_IDLE;
         ap_pend_q <= 1'b0;
         viol      <= 1'b0;
      end else begin
         viol <= bad;
         if (leg_act)                          st_q <= BK_OPEN;
         else if (start_pre)                   st_q <= close_st;
         else if (st_q == BK_CLOSING && rp_last) st_q <= BK_IDLE;
         if (fire)         ap_pend_q <= 1'b0;
         else if (leg_rda) ap_pend_q <= 1'b1;
      end
   end

endmodule

// File: rtl/bank_pre_guard.sv
`timescale 1ns/1ps
module bank_pre_guard
   import bpg_pkg::*;
#(
   parameter int CLK_PS    = 4000,
   parameter int TRAS_PS   = 42000,
   parameter int TRP_PS    = 15000,
   parameter int CAS_LAT   = 3,
   parameter int BURST_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_act,
   input  logic cmd_rd,
   input  logic cmd_rda,
   input  logic cmd_pre,
   output logic act_ok,
   output logic pre_ok,
   output logic viol
);

   localparam int TRAS_CYC  = ceil_div(TRAS_PS, CLK_PS);
   localparam int TRP_CYC   = ceil_div(TRP_PS, CLK_PS);
   localparam int BURST_END = CAS_LAT + BURST_LEN / 2;
   localparam int AP_OFS    = BURST_END - CAS_LAT;
   localparam int CW        = $clog2(max3(TRAS_CYC, TRP_CYC, AP_OFS) + 1);

   generate
      if (CLK_PS < 1) begin : g_bad_clk
         $error("CLK_PS must be positive");
      end
      if (TRAS_CYC < 1 || TRP_CYC < 1) begin : g_bad_delay
         $error("TRAS_PS and TRP_PS must be positive");
      end
      if (CAS_LAT < 1) begin : g_bad_cl
         $error("CAS_LAT must be at least 1");
      end
      if (BURST_LEN < 2 || (BURST_LEN % 2) != 0) begin : g_bad_bl
         $error("BURST_LEN must be an even value of 2 or more");
      end
   endgenerate

   logic          ld_ras, ld_ap, ld_rp;
   logic          ras_zero, ap_zero, rp_zero;
   logic [CW-1:0] ras_cnt, ap_cnt, rp_cnt;

   bpg_down_cnt #(.CW(CW)) u_ras_cnt (
      .clk(clk), .rst_n(rst_n), .load(ld_ras),
      .load_val(CW'(TRAS_CYC - 1)), .cnt(ras_cnt), .zero(ras_zero)
   );

   bpg_down_cnt #(.CW(CW)) u_ap_cnt (
      .clk(clk), .rst_n(rst_n), .load(ld_ap),
      .load_val(CW'(AP_OFS - 1)), .cnt(ap_cnt), .zero(ap_zero)
   );

   bpg_down_cnt #(.CW(CW)) u_rp_cnt (
      .clk(clk), .rst_n(rst_n), .load(ld_rp),
      .load_val(CW'(TRP_CYC - 1)), .cnt(rp_cnt), .zero(rp_zero)
   );

   bpg_bank_fsm #(.TRP_SINGLE(TRP_CYC == 1)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_rda(cmd_rda), .cmd_pre(cmd_pre),
      .ras_zero(ras_zero), .ap_zero(ap_zero), .rp_last(rp_cnt == CW'(1)),
      .act_ok(act_ok), .pre_ok(pre_ok), .viol(viol),
      .ld_ras(ld_ras), .ld_ap(ld_ap), .ld_rp(ld_rp)
   );

endmodule

// File: rtl/bpg_checker.sv
`timescale 1ns/1ps
module bpg_checker #(
   parameter int TRAS_CYC = 2
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_act,
   input logic cmd_rd,
   input logic cmd_rda,
   input logic cmd_pre,
   input logic act_ok,
   input logic pre_ok,
   input logic viol
);

   logic [3:0] cmds;
   assign cmds = {cmd_act, cmd_rd, cmd_rda, cmd_pre};

   p_bad_act_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_act && !act_ok) |=> viol);

   p_act_ok_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ok && !(cmd_act && $countones(cmds) == 1)) |=> act_ok);

   p_bad_pre_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pre && !pre_ok) |=> viol);

   p_ras_after_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (TRAS_CYC > 1 && act_ok && cmd_act && $countones(cmds) == 1) |=> !pre_ok);

   p_rd_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_rd || cmd_rda) && act_ok) |=> viol);

   p_multi_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(cmds) > 1) |=> viol);

   p_quiet_no_viol_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmds == 4'b0000) |=> !viol);

   p_ok_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_ok && pre_ok));

endmodule

bind bank_pre_guard bpg_checker #(.TRAS_CYC(TRAS_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_rda(cmd_rda), .cmd_pre(cmd_pre),
   .act_ok(act_ok), .pre_ok(pre_ok), .viol(viol)
);

// File: tb/bank_pre_guard_tb.sv
`timescale 1ns/1ps
module bank_pre_guard_tb_top;

   localparam int CLK_PS = 4000;
   localparam int TRAS_PS = 42000;
   localparam int TRP_PS = 15000;
   localparam int BL = 8;
   localparam int TRAS_N = (TRAS_PS + CLK_PS - 1) / CLK_PS;
   localparam int TRP_N = (TRP_PS + CLK_PS - 1) / CLK_PS;
   localparam int AP_N = BL / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_act = 1'b0, cmd_rd = 1'b0, cmd_rda = 1'b0, cmd_pre = 1'b0;
   logic act_ok, pre_ok, viol;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   int  cyc = 0;
   bit  m_open = 1'b0, m_ap = 1'b0, m_viol = 1'b0;
   int  t_act = -1000, t_pre = -1000, t_rda = -1000;

   always #2 clk = ~clk;

   bank_pre_guard #(.CLK_PS(CLK_PS), .TRAS_PS(TRAS_PS), .TRP_PS(TRP_PS),
                    .CAS_LAT(3), .BURST_LEN(BL)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_rd(cmd_rd),
      .cmd_rda(cmd_rda), .cmd_pre(cmd_pre),
      .act_ok(act_ok), .pre_ok(pre_ok), .viol(viol));

   function automatic bit f_act_ok();
      return !m_open && (cyc >= t_pre + TRP_N);
   endfunction

   function automatic bit f_pre_ok();
      return m_open && !m_ap && (cyc >= t_act + TRAS_N);
   endfunction

   function automatic bit f_fire();
      return m_open && m_ap && (cyc >= t_rda + AP_N) && (cyc >= t_act + TRAS_N);
   endfunction

   task automatic check(input string tag, input string sig, input bit act, input bit exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s cyc=%0d actual=%0b expected=%0b", tag, sig, cyc, act, exp);
      end
   endtask

   // One cycle: check outputs at negedge, drive command, advance model.
   task automatic step(input string tag, input bit a, input bit r, input bit ra, input bit p);
      bit e_act, e_pre, fire, legal;
      int n;
      e_act = f_act_ok();
      e_pre = f_pre_ok();
      fire  = f_fire();
      check(tag, "act_ok", act_ok, e_act);
      check(tag, "pre_ok", pre_ok, e_pre);
      check(tag, "viol", viol, m_viol);
      cmd_act = a; cmd_rd = r; cmd_rda = ra; cmd_pre = p;
      n = int'(a) + int'(r) + int'(ra) + int'(p);
      legal = (n == 1) && ((a && e_act) || (p && e_pre) ||
                           ((r || ra) && m_open && !m_ap));
      m_viol = (n > 0) && !legal;
      if (fire) begin m_open = 1'b0; m_ap = 1'b0; t_pre = cyc; end
      if (legal) begin
         if (a) begin m_open = 1'b1; t_act = cyc; end
         if (p) begin m_open = 1'b0; t_pre = cyc; end
         if (ra) begin m_ap = 1'b1; t_rda = cyc; end
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(input string tag, input int k);
      for (int i = 0; i < k; i++) step(tag, 0, 0, 0, 0);
   endtask

   initial begin
      int r;
      r = $urandom(32'd24680);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1", "act_ok", act_ok, 1'b1);
      check("R1", "pre_ok", pre_ok, 1'b0);
      check("R1", "viol", viol, 1'b0);
      // R6 / R5: read and precharge to a closed bank
      step("R6", 0, 1, 0, 0);
      step("R5", 0, 0, 0, 1);
      step("R6", 0, 0, 1, 0);
      idle("R11", 2);
      // R2: precharge one cycle short of row-open time, then on time
      step("R2", 1, 0, 0, 0);
      idle("R2", TRAS_N - 2);
      step("R5", 0, 0, 0, 1);
      step("R2", 0, 0, 0, 1);
      // R3 / R4: activate one cycle before recovery, then on time
      idle("R3", TRP_N - 2);
      step("R4", 1, 0, 0, 0);
      step("R4", 1, 0, 0, 0);
      // R8 / R9: early auto-close read is postponed until row-open time
      step("R8", 0, 0, 1, 0);
      step("R9", 0, 0, 0, 1);
      step("R6", 0, 1, 0, 0);
      idle("R8", TRAS_N + TRP_N);
      // R7: late auto-close read fires after half a burst
      step("R7", 1, 0, 0, 0);
      idle("R7", TRAS_N);
      step("R7", 0, 1, 0, 0);
      step("R7", 0, 0, 1, 0);
      idle("R7", AP_N + TRP_N + 1);
      // R10: two strobes together
      step("R10", 1, 0, 0, 1);
      step("R10", 1, 1, 0, 0);
      idle("R11", 2);
      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         r = int'($urandom % 20);
         case (r)
            0, 1:    step("RND", 1, 0, 0, 0);
            2, 3:    step("RND", 0, 0, 0, 1);
            4:       step("RND", 0, 1, 0, 0);
            5:       step("RND", 0, 0, 1, 0);
            6:       step("RND", 1, 0, 1, 0);
            default: step("RND", 0, 0, 0, 0);
         endcase
      end
      idle("R11", 2);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired at cyc=%0d actual=hung expected=done", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule